// File: doc/BRIEF.md
# Two-Wire Debug Target Serial Engine

This block is the target side of a Serial Wire Debug link. The host supplies the serial clock, and the engine runs directly on that clock. It samples the shared data line on each rising edge. It drives the line through a separate output and output-enable pair, and it enables the driver only while it owns the line.

Each transaction follows the same fixed order:

1. An 8-bit request.
2. A turnaround, whose length is set by an input.
3. A 3-bit acknowledge.
4. For a successful transfer, a 32-bit data word with an even parity bit, sent in the direction the request asked for.

All fields travel least significant bit first.

On its inner side the engine offers a small register port:
- a one-cycle read strobe or write strobe;
- a bank select and a 2-bit register address;
- write data;
- read data;
- wait and fault status inputs;
- a sticky data-parity error flag with its clear input.

A malformed request gets no reply at all. The engine then locks out and ignores the line until it sees a line reset. It also starts in this lockout state after its own reset.

Top module: `swd_target`

## Requirements
- R1: `dio_oe` is high only in the three acknowledge cycles and the 33 read-data cycles. In every other cycle the line is left undriven, including every turnaround of `turn_len`+1 cycles.
- R2: A request must be exactly the sequence 1, bank, RnW, A2, A3, parity, 0, 1. For a valid request, the acknowledge starts on the edge `turn_len`+1 cycles after the park-bit edge. It is driven LSB first, with OK=3'b001, WAIT=3'b010 and FAULT=3'b100. Here A2 is `reg_addr[0]` and A3 is `reg_addr[1]`.
- R3: The acknowledge is chosen at the park-bit edge. It is FAULT if `reg_fault` or `sticky_err` is high, else WAIT if `reg_wait` is high, else OK.
- R4: A read answered OK pulses `reg_rd` for one cycle, right after the park-bit edge. The engine captures `reg_rdata` at the end of that cycle. It then drives the 32 data bits LSB first, followed by their even parity bit. After that it releases the line for `turn_len`+1 cycles.
- R5: A write answered OK releases the line after the acknowledge and waits `turn_len`+1 cycles. It then samples 32 data bits and a parity bit. If the parity is good, `reg_wr` pulses for one cycle after the parity edge, carrying the data, bank and address.
- R6: A write with bad data parity gives no `reg_wr` pulse, so the register is unchanged, and it sets `sticky_err`.
- R7: `sticky_err` stays high until `err_clr` is sampled high. While it is set, every acknowledge is FAULT.
- R8: After WAIT or FAULT there is no data phase and no strobe. The line is released for `turn_len`+1 cycles, and then the next request is accepted.
- R9: A request with a wrong parity, stop or park bit is never answered. The engine then ignores all further requests until a line reset.
- R10: A line reset is 50 consecutive high samples on the undriven line, followed by 2 low samples. After it, requests are accepted. 49 highs are not enough. After `rst_n`, the engine also waits for a line reset.
- R11: During reset, `dio_oe`, `reg_rd`, `reg_wr` and `sticky_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| swclk | input | 1 | Host-driven serial clock |
| rst_n | input | 1 | Active-low reset |
| dio_in | input | 1 | Sampled data line |
| dio_out | output | 1 | Value driven onto the data line |
| dio_oe | output | 1 | Driver enable for the data line |
| turn_len | input | 2 | Turnaround length minus one, in cycles |
| reg_ap | output | 1 | Bank select from the request |
| reg_addr | output | 2 | Register address {A3, A2} |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid during the `reg_rd` cycle |
| reg_wait | input | 1 | Register side asks for WAIT |
| reg_fault | input | 1 | Register side asks for FAULT |
| err_clr | input | 1 | Clears the sticky error flag |
| sticky_err | output | 1 | Sticky write-data parity error flag |

## Verification
The assertions check these properties on every cycle:
- the strobes last one cycle and never coincide;
- no strobe occurs while the target drives the line;
- the lockout state never drives the line or strobes;
- the sticky flag holds until it is cleared.

The bench scenarios cover what needs the exact bit stream:
- the placement of the acknowledge for every turnaround length;
- the encoding and priority of the acknowledge;
- read data and parity;
- writes proven by later read-back;
- discarded writes;
- silence on malformed requests;
- the 49- versus 50-cycle boundary of the line reset.

// File: rtl/swd_target.sv
module swd_target #(
  parameter int RESET_LEN = 50,
  parameter int IDLE_MIN  = 2,
  parameter int TW        = 2,
  parameter int DW        = 32
) (
  input  logic          swclk,
  input  logic          rst_n,
  input  logic          dio_in,
  output logic          dio_out,
  output logic          dio_oe,
  input  logic [TW-1:0] turn_len,
  output logic          reg_ap,
  output logic [1:0]    reg_addr,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic          reg_wait,
  input  logic          reg_fault,
  input  logic          err_clr,
  output logic          sticky_err
);
  localparam int HW   = $clog2(RESET_LEN + 1);
  localparam int CMAX = (DW > (1 << TW)) ? ((DW > IDLE_MIN) ? DW : IDLE_MIN)
                                         : (((1 << TW) > IDLE_MIN) ? (1 << TW) : IDLE_MIN);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [2:0] ACK_OK = 3'b001, ACK_WAIT = 3'b010, ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    S_LOCK, S_LRST, S_IDLE, S_REQ, S_TRN1, S_ACK, S_WTRN, S_WDAT, S_RDAT, S_TRN2
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hi_cnt;
  logic [6:0]    req_sh;
  logic [2:0]    ack;
  logic          rnw_q;
  logic [DW:0]   sh;

  logic [6:0]    req_nx;
  logic [DW:0]   sh_in;
  logic          req_ok, lr_hit, last_turn;
  logic [2:0]    ack_sel;

  assign req_nx    = {dio_in, req_sh[6:1]};
  assign sh_in     = {dio_in, sh[DW:1]};
  assign req_ok    = ~^req_nx[4:0] & ~req_nx[5] & req_nx[6];
  assign lr_hit    = ~dio_oe & dio_in & (hi_cnt == HW'(RESET_LEN - 1));
  assign last_turn = (cnt == CW'(turn_len));
  assign ack_sel   = (reg_fault | sticky_err) ? ACK_FAULT : reg_wait ? ACK_WAIT : ACK_OK;

  always_ff @(posedge swclk) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (dio_oe || !dio_in) hi_cnt <= '0;
    else if (hi_cnt != HW'(RESET_LEN)) hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge swclk) begin
    if (!rst_n) begin
      state      <= S_LOCK;
      cnt        <= '0;
      req_sh     <= '0;
      ack        <= ACK_OK;
      rnw_q      <= 1'b0;
      sh         <= '0;
      dio_out    <= 1'b0;
      dio_oe     <= 1'b0;
      reg_ap     <= 1'b0;
      reg_addr   <= '0;
      reg_rd     <= 1'b0;
      reg_wr     <= 1'b0;
      reg_wdata  <= '0;
      sticky_err <= 1'b0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      if (err_clr) sticky_err <= 1'b0;
      if (lr_hit) begin
        state  <= S_LRST;
        cnt    <= '0;
        dio_oe <= 1'b0;
      end else begin
        case (state)
          S_LRST:
            if (dio_in) cnt <= '0;
            else if (cnt == CW'(IDLE_MIN - 1)) state <= S_IDLE;
            else cnt <= cnt + 1'b1;
          S_IDLE:
            if (dio_in) begin
              state <= S_REQ;
              cnt   <= '0;
            end
          S_REQ: begin
            req_sh <= req_nx;
            if (cnt == CW'(6)) begin
              cnt <= '0;
              if (req_ok) begin
                state    <= S_TRN1;
                reg_ap   <= req_nx[0];
                rnw_q    <= req_nx[1];
                reg_addr <= {req_nx[3], req_nx[2]};
                ack      <= ack_sel;
                reg_rd   <= req_nx[1] & (ack_sel == ACK_OK);
              end else begin
                state <= S_LOCK;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TRN1: begin
            if (reg_rd) sh <= {^reg_rdata, reg_rdata};
            if (last_turn) begin
              state   <= S_ACK;
              dio_oe  <= 1'b1;
              dio_out <= ack[0];
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ACK:
            if (cnt != CW'(2)) begin
              dio_out <= ack[cnt[1:0] + 2'd1];
              cnt     <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (ack == ACK_OK && rnw_q) begin
                state   <= S_RDAT;
                dio_out <= sh[0];
                sh      <= {1'b0, sh[DW:1]};
              end else begin
                state  <= (ack == ACK_OK) ? S_WTRN : S_TRN2;
                dio_oe <= 1'b0;
              end
            end
          S_RDAT:
            if (cnt == CW'(DW)) begin
              state  <= S_TRN2;
              dio_oe <= 1'b0;
              cnt    <= '0;
            end else begin
              dio_out <= sh[0];
              sh      <= {1'b0, sh[DW:1]};
              cnt     <= cnt + 1'b1;
            end
          S_WTRN:
            if (last_turn) begin
              state <= S_WDAT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_WDAT: begin
            sh <= sh_in;
            if (cnt == CW'(DW)) begin
              state <= S_IDLE;
              cnt   <= '0;
              if (~^sh_in) begin
                reg_wr    <= 1'b1;
                reg_wdata <= sh_in[DW-1:0];
              end else begin
                sticky_err <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TRN2:
            if (last_turn) begin
              state <= S_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swd_target_chk.sv
module swd_target_chk (
  input logic clk,
  input logic rst_n,
  input logic dio_oe,
  input logic reg_rd,
  input logic reg_wr,
  input logic sticky_err,
  input logic err_clr,
  input logic locked
);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  assert_rd_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !dio_oe);
  assert_wr_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !dio_oe);
  assert_lock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!dio_oe && !reg_rd && !reg_wr));
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_err && !err_clr) |=> sticky_err);
endmodule

bind swd_target swd_target_chk chk (
  .clk(swclk), .rst_n(rst_n), .dio_oe(dio_oe), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .sticky_err(sticky_err), .err_clr(err_clr), .locked(state == S_LOCK)
);

// File: tb/swd_target_test.sv
`timescale 1ns/1ps
module swd_target_test;
  logic        swclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dio_in = 1'b0;
  logic        dio_out, dio_oe;
  logic [1:0]  turn_len = 2'd0;
  logic        reg_ap;
  logic [1:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_wait = 1'b0, reg_fault = 1'b0, err_clr = 1'b0;
  logic        sticky_err;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] dut_regs [8];
  logic [31:0] model_regs [8];
  bit model_locked = 1;
  bit model_sticky = 0;

  always #2.5 swclk = ~swclk;

  swd_target uut (
    .swclk(swclk), .rst_n(rst_n), .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
    .turn_len(turn_len), .reg_ap(reg_ap), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
    .reg_fault(reg_fault), .err_clr(err_clr), .sticky_err(sticky_err)
  );

  assign reg_rdata = dut_regs[{reg_ap, reg_addr}];
  always @(posedge swclk) if (reg_wr) dut_regs[{reg_ap, reg_addr}] <= reg_wdata;

  task automatic step(input logic din, input logic eoe, input logic eout,
                      input logic erd, input logic ewr, input string tag);
    dio_in = din;
    @(posedge swclk);
    #1;
    total++;
    if (dio_oe !== eoe || (eoe && dio_out !== eout) || reg_rd !== erd || reg_wr !== ewr) begin
      bad++;
      $display("FAIL %s: oe=%b out=%b rd=%b wr=%b expected oe=%b out=%b rd=%b wr=%b",
               tag, dio_oe, dio_out, reg_rd, reg_wr, eoe, eout, erd, ewr);
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic line_reset(input int highs, input int lows, input string tag);
    for (int i = 0; i < highs; i++) step(1'b1, 0, 0, 0, 0, tag);
    for (int i = 0; i < lows; i++) step(1'b0, 0, 0, 0, 0, tag);
    if (highs >= 50 && lows >= 2) model_locked = 0;
  endtask

  // err: 0 none, 1 request parity, 2 stop, 3 park
  task automatic xfer(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                      input int err, input bit bad_dpar, input string tag);
    logic [7:0]  b;
    logic [2:0]  ack;
    logic [31:0] d;
    bit resp, ok, good;
    int t;
    t = int'(turn_len) + 1;
    b = {1'b1, 1'b0, a[1] ^ a[0] ^ rnw ^ ap, a[1], a[0], rnw, ap, 1'b1};
    if (err == 1) b[5] = ~b[5];
    if (err == 2) b[6] = 1'b1;
    if (err == 3) b[7] = 1'b0;
    resp = !model_locked && err == 0;
    if (err != 0) model_locked = 1;
    ack = (reg_fault || model_sticky) ? 3'b100 : reg_wait ? 3'b010 : 3'b001;
    ok = (ack == 3'b001);
    for (int i = 0; i < 7; i++) step(b[i], 0, 0, 0, 0, tag);
    step(b[7], 0, 0, resp && rnw && ok, 0, tag);
    if (!resp) begin
      for (int i = 0; i < t + 3; i++) step(1'b0, 0, 0, 0, 0, tag);
      return;
    end
    for (int i = 0; i < t - 1; i++) step(1'b0, 0, 0, 0, 0, tag);
    for (int i = 0; i < 3; i++) step(1'b0, 1, ack[i], 0, 0, tag);
    if (ok && rnw) begin
      d = model_regs[{ap, a}];
      for (int i = 0; i < 32; i++) step(1'b0, 1, d[i], 0, 0, tag);
      step(1'b0, 1, ^d, 0, 0, tag);
      for (int i = 0; i < t + 1; i++) step(1'b0, 0, 0, 0, 0, tag);
    end else if (ok) begin
      good = !bad_dpar;
      for (int i = 0; i < t + 1; i++) step(1'b0, 0, 0, 0, 0, tag);
      for (int i = 0; i < 32; i++) step(wd[i], 0, 0, 0, 0, tag);
      step((^wd) ^ bad_dpar, 0, 0, 0, good, tag);
      if (good) model_regs[{ap, a}] = wd;
      else model_sticky = 1;
      chk(tag, sticky_err, model_sticky);
      step(1'b0, 0, 0, 0, 0, tag);
    end else begin
      for (int i = 0; i < t + 1; i++) step(1'b0, 0, 0, 0, 0, tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      dut_regs[i]   = 32'h1357_9BDF ^ (i * 32'h0101_0101);
      model_regs[i] = dut_regs[i];
    end
    repeat (3) @(posedge swclk);
    #1;
    chk("R11 oe", dio_oe, 1'b0);
    chk("R11 rd", reg_rd, 1'b0);
    chk("R11 wr", reg_wr, 1'b0);
    chk("R11 sticky", sticky_err, 1'b0);
    rst_n = 1'b1;

    xfer(0, 1, 2'd0, 0, 0, 0, "R10 no reply before line reset");
    line_reset(50, 2, "R10");

    turn_len = 2'd0;
    xfer(0, 0, 2'd1, 32'hDEAD_BEEF, 0, 0, "R5 write t1");
    xfer(0, 1, 2'd1, 0, 0, 0, "R4 read back t1");
    xfer(1, 1, 2'd2, 0, 0, 0, "R2 read bank1 t1");

    turn_len = 2'd2;
    xfer(1, 1, 2'd3, 0, 0, 0, "R4 read t3");
    xfer(1, 0, 2'd3, 32'h8000_0001, 0, 0, "R5 write t3");
    xfer(1, 1, 2'd3, 0, 0, 0, "R4 read back t3");
    xfer(0, 0, 2'd2, 32'h0000_0000, 0, 0, "R5 write zero");
    xfer(0, 1, 2'd2, 0, 0, 0, "R4 read zero");

    turn_len = 2'd3;
    xfer(0, 1, 2'd1, 0, 0, 0, "R2 read t4");
    xfer(1, 0, 2'd0, 32'hFFFF_FFFE, 0, 0, "R5 write t4");
    xfer(1, 1, 2'd0, 0, 0, 0, "R4 read back t4");

    turn_len = 2'd1;
    reg_wait = 1'b1;
    xfer(0, 1, 2'd3, 0, 0, 0, "R8 read wait");
    xfer(0, 0, 2'd3, 32'h1234_5678, 0, 0, "R8 write wait");
    reg_fault = 1'b1;
    xfer(0, 1, 2'd3, 0, 0, 0, "R3 fault over wait");
    reg_wait = 1'b0;
    xfer(1, 0, 2'd1, 32'h0F0F_0F0F, 0, 0, "R3 write fault");
    reg_fault = 1'b0;
    xfer(0, 1, 2'd3, 0, 0, 0, "R8 reg unchanged after wait");

    xfer(1, 0, 2'd2, 32'hCAFE_F00D, 0, 1, "R6 bad data parity");
    xfer(1, 1, 2'd2, 0, 0, 0, "R7 sticky forces fault");
    err_clr = 1'b1;
    step(1'b0, 0, 0, 0, 0, "R7 clear");
    err_clr = 1'b0;
    model_sticky = 0;
    chk("R7 cleared", sticky_err, 1'b0);
    xfer(1, 1, 2'd2, 0, 0, 0, "R6 write discarded");

    xfer(0, 1, 2'd1, 0, 1, 0, "R9 bad request parity");
    xfer(0, 1, 2'd1, 0, 0, 0, "R9 lockout");
    line_reset(49, 2, "R10 short reset");
    xfer(0, 1, 2'd1, 0, 0, 0, "R10 still locked after 49");
    line_reset(50, 2, "R10");
    xfer(0, 1, 2'd1, 0, 0, 0, "R10 unlocked");
    xfer(1, 0, 2'd0, 0, 2, 0, "R9 bad stop");
    line_reset(50, 2, "R10");
    xfer(1, 0, 2'd0, 0, 3, 0, "R9 bad park");
    xfer(1, 0, 2'd0, 32'h5555_AAAA, 0, 0, "R9 locked write");
    line_reset(50, 2, "R10");
    xfer(1, 1, 2'd0, 0, 0, 0, "R9 locked write not applied");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule